// File: doc/BRIEF.md
# Two-Click Lamp Switch Controller

This block turns a single push-button line into a lamp enable. The line is the OR of any number of active-high buttons placed around a room; an active-low button is inverted before it joins the OR. The controller counts whole clicks, a click being a press followed by a release. The second click switches the lamp on and the third switches it off, after which the count starts again. In fact the lamp lights as soon as the second press is seen and goes dark as soon as the third press is seen. The final release then returns the machine to its idle state.

The controller is a Moore machine built from three parts: a state register, next-state logic fed by the present state and the button, and output logic fed only by the present state. It runs from a slow system clock of about 200 Hz and has an asynchronous reset. A 3-bit state code is brought out so that a display can show the sequence while the system is being brought up. A parameter selects the state register style. The binary style uses three flip-flops and the one-hot style uses six. Both styles behave the same at the ports. The button is expected to be debounced and synchronised before it reaches this block.

Top module: `lamp_click_fsm`

## Requirements
- R1: While `rst` is high, `state_code` is 0 and `lamp_on` is 0 at once, without waiting for a clock edge, and they stay so until reset is released.
- R2: From code 0 (idle, lamp off), a clock edge that samples `btn` high moves to code 1 (first press held).
- R3: From code 1 a low `btn` at an edge moves to code 2 (first release), and from code 2 a high `btn` moves to code 3 (second press held).
- R4: `lamp_on` is 1 exactly when `state_code` is 3 or 4, so the lamp lights on the edge that takes in the second press.
- R5: From code 3 a low `btn` moves to code 4 (lamp on, button released), and from code 4 a high `btn` moves to code 5 (third press held) with the lamp off.
- R6: From code 5 a low `btn` returns to code 0, and the six-step sequence then repeats without limit.
- R7: A button level held for any number of cycles causes no change of state. There is no timeout, so code 2 is kept however long the wait for the next press.
- R8: The outputs depend only on the registered state. A change of `btn` between clock edges does not alter them, and a new state shows one edge after the button level that causes it.
- R9: With `ONE_HOT` at 1 the state is held in six flip-flops with exactly one set. With `ONE_HOT` at 0 it is held in three. Port behaviour is identical in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, about 200 Hz |
| rst | input | 1 | Asynchronous reset, active high |
| btn | input | 1 | OR of all active-high buttons, debounced |
| lamp_on | output | 1 | Lamp enable, high when the lamp is lit |
| state_code | output | 3 | Binary code of the present state, 0 to 5 |

## Verification
Every state change and the matching lamp level are due one rising edge after the button level is applied. The bench drives `btn` on the falling edge and samples both outputs on the next falling edge, so exactly one register stage lies between stimulus and check. The effect of reset is due with no edge at all, so it is sampled 1 ns after `rst` rises in the middle of a cycle. Similarly, the check that a mid-cycle button change has no effect on the outputs is made before the next rising edge. A binary instance and a one-hot instance are driven side by side and both are compared against the same expected values.

// File: rtl/lamp_click_fsm.sv
module lamp_click_fsm #(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn,
  output logic       lamp_on,
  output logic [2:0] state_code
);

  localparam int NUM_ST = 6;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_P1   = 3'd1,
    S_R1   = 3'd2,
    S_P2   = 3'd3,
    S_HOLD = 3'd4,
    S_P3   = 3'd5
  } st_t;

  st_t cur, nxt;

  always_comb begin
    nxt = cur;
    unique case (cur)
      S_IDLE:  if (btn)  nxt = S_P1;
      S_P1:    if (!btn) nxt = S_R1;
      S_R1:    if (btn)  nxt = S_P2;
      S_P2:    if (!btn) nxt = S_HOLD;
      S_HOLD:  if (btn)  nxt = S_P3;
      S_P3:    if (!btn) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  generate
    if (ONE_HOT) begin : g_oh
      logic [NUM_ST-1:0] oh;

      always_ff @(posedge clk or posedge rst)
        if (rst) oh <= NUM_ST'(1);
        else     oh <= NUM_ST'(1) << nxt;

      always_comb begin
        cur = S_IDLE;
        for (int i = 0; i < NUM_ST; i++)
          if (oh[i]) cur = st_t'(3'(i));
      end

      // R9
      onehot_reg_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(oh) == 1);
    end else begin : g_bin
      st_t q;

      always_ff @(posedge clk or posedge rst)
        if (rst) q <= S_IDLE;
        else     q <= nxt;

      assign cur = q;
    end
  endgenerate

  assign lamp_on    = (cur == S_P2) || (cur == S_HOLD);
  assign state_code = cur;

  // R6
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    state_code <= 3'd5);

  // R2 R3 R5 R6
  step_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code != $past(state_code)) |->
      (state_code == (($past(state_code) == 3'd5) ? 3'd0 : $past(state_code) + 3'd1)));

  // R7
  press_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (btn && state_code[0]) |=> $stable(state_code));

  // R7
  release_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!btn && !state_code[0]) |=> $stable(state_code));

  // R4
  lamp_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lamp_on) |-> ($past(state_code) == 3'd2));

  // R4 R5
  lamp_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lamp_on) |-> (state_code == 3'd5));

endmodule

// File: tb/lamp_click_fsm_bench.sv
`timescale 1ns/1ps
module lamp_click_fsm_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic       lamp_b, lamp_h;
  logic [2:0] code_b, code_h;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  lamp_click_fsm #(.ONE_HOT(1'b0)) u_lamp_click_fsm (
    .clk(clk), .rst(rst), .btn(btn), .lamp_on(lamp_b), .state_code(code_b));

  lamp_click_fsm #(.ONE_HOT(1'b1)) u_lamp_click_fsm_oh (
    .clk(clk), .rst(rst), .btn(btn), .lamp_on(lamp_h), .state_code(code_h));

  // {btn, expected code, expected lamp}
  localparam int NV = 18;
  localparam logic [4:0] VEC [NV] = '{
    {1'b0, 3'd0, 1'b0}, {1'b1, 3'd1, 1'b0}, {1'b1, 3'd1, 1'b0},
    {1'b0, 3'd2, 1'b0}, {1'b0, 3'd2, 1'b0}, {1'b1, 3'd3, 1'b1},
    {1'b1, 3'd3, 1'b1}, {1'b0, 3'd4, 1'b1}, {1'b0, 3'd4, 1'b1},
    {1'b1, 3'd5, 1'b0}, {1'b1, 3'd5, 1'b0}, {1'b0, 3'd0, 1'b0},
    {1'b1, 3'd1, 1'b0}, {1'b0, 3'd2, 1'b0}, {1'b1, 3'd3, 1'b1},
    {1'b0, 3'd4, 1'b1}, {1'b1, 3'd5, 1'b0}, {1'b0, 3'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [2:0] ec, input logic el);
    checks++;
    if (code_b !== ec || lamp_b !== el) begin
      failures++;
      $display("FAIL %s binary: code=%0d lamp=%0b expected code=%0d lamp=%0b",
               req, code_b, lamp_b, ec, el);
    end
    checks++;
    if (code_h !== ec || lamp_h !== el) begin
      failures++;
      $display("FAIL %s one-hot (R9): code=%0d lamp=%0b expected code=%0d lamp=%0b",
               req, code_h, lamp_h, ec, el);
    end
  endtask

  task automatic step(input logic b);
    btn = b;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", 3'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", 3'd0, 1'b0);

    // R2 R3 R4 R5 R6: two full rounds of the sequence
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4]);
      chk("R2/R3/R4/R5/R6 vector", VEC[i][3:1], VEC[i][0]);
    end

    // R7: long press hold in code 1
    step(1'b1);
    chk("R2 press", 3'd1, 1'b0);
    for (int i = 0; i < 60; i++) step(1'b1);
    chk("R7 long press", 3'd1, 1'b0);

    // R7: no timeout in code 2
    step(1'b0);
    chk("R3 release", 3'd2, 1'b0);
    for (int i = 0; i < 150; i++) step(1'b0);
    chk("R7 no timeout", 3'd2, 1'b0);

    // R8: mid-cycle change has no effect before the edge
    btn = 1'b1;
    #1;
    chk("R8 before edge", 3'd2, 1'b0);
    @(negedge clk);
    chk("R8 after edge", 3'd3, 1'b1);

    // R1: asynchronous reset mid-cycle with lamp on
    rst = 1'b1;
    #1;
    chk("R1 async", 3'd0, 1'b0);
    @(negedge clk);
    chk("R1 held with btn high", 3'd0, 1'b0);
    btn = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 released idle", 3'd0, 1'b0);
    step(1'b1);
    chk("R2 after reset", 3'd1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule